// File: doc/BRIEF.md
# Vector Immediate Shift-Right Unit

This unit takes one 32-bit "vector shift right by immediate" instruction word together with the source vector value and returns the shifted vector. The instruction word is decoded directly: a width bit and a packed 6-bit field together set both the lane width (8, 16, 32 or 64 bits) and the shift count. A select bit chooses between a zero-filling and a sign-filling shift. A quad bit chooses between a 128-bit and a 64-bit operation.

Every lane of the operand is shifted right by the same count. The unit also forms the destination register index and flags encodings that are not legal. Results leave one registered cycle after the input strobe. The surrounding pipeline reads the source register, supplies it on `src_vec`, and writes `res_vec` back to the index on `res_dst`. It raises an exception whenever `res_undef` is high.

Top module: `vshr_imm_unit`

## Requirements
- R1: A word is accepted only if bits [31:25]=1111001, bit 23=1, bits [11:8]=0000 and bit 4=1. Any other word is reported as undefined. Field positions: U=bit 24, D=bit 22, imm6=bits [21:16], Vd=bits [15:12], L=bit 7, Q=bit 6, M=bit 5, Vm=bits [3:0].
- R2: With L=1, lanes are 64 bits wide and the shift count is 64 minus imm6.
- R3: With L=0, the leading one of imm6[5:3] sets the lane width. 001 gives 8-bit lanes with count 16-imm6. 01x gives 16-bit lanes with count 32-imm6. 1xx gives 32-bit lanes with count 64-imm6.
- R4: With L=0 and imm6[5:3]=000, the word is undefined.
- R5: With Q=1, the word is undefined if bit 0 of Vd or bit 0 of Vm is 1.
- R6: U=1 shifts each lane logically, filling with zeros. U=0 shifts arithmetically, filling with copies of the lane's top bit.
- R7: A count equal to the lane width gives all zeros for a logical shift. For an arithmetic shift it gives every bit equal to the lane's sign bit.
- R8: With Q=0, only src_vec[63:0] is processed and res_vec[127:64] is zero. With Q=1, all 128 bits are processed.
- R9: res_dst is {D,Vd} when Q=0 and {D,Vd}>>1 when Q=1.
- R10: One cycle after an in_valid cycle, res_valid=1 for a legal word, or res_undef=1 with res_vec and res_dst zero for an illegal word. With no input strobe, both are 0 the next cycle.
- R11: While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operand present this cycle |
| insn | input | 32 | Instruction word |
| src_vec | input | 128 | Source register value |
| res_valid | output | 1 | Legal result present |
| res_undef | output | 1 | Undefined-instruction flag |
| res_vec | output | 128 | Shifted vector |
| res_dst | output | 5 | Destination register index |

## Verification
The assertions assume that `in_valid` is a known value in every cycle after reset. They also assume that `insn` is known whenever `in_valid` is high, because the decoded count range and the upper-half zero check both read the word in that cycle. The bench changes inputs only on the falling clock edge. It sends each word as a single-cycle pulse and returns `insn` and `src_vec` to zero between pulses, so no undefined value ever meets a strobe.

// File: rtl/vshr_imm_unit.sv
module vshr_imm_unit (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [31:0]  insn,
  input  logic [127:0] src_vec,
  output logic         res_valid,
  output logic         res_undef,
  output logic [127:0] res_vec,
  output logic [4:0]   res_dst
);
  localparam int VW = 128;

  logic       f_u, f_l, f_q;
  logic [5:0] imm;
  logic [4:0] dreg;
  logic       pat_ok, bad;
  logic [1:0] sz;
  logic [6:0] cnt;
  logic [VW-1:0] lane_res [4];
  logic [VW-1:0] picked, shaped;

  assign f_u  = insn[24];
  assign imm  = insn[21:16];
  assign f_l  = insn[7];
  assign f_q  = insn[6];
  assign dreg = {insn[22], insn[15:12]};

  assign pat_ok = (insn[31:25] == 7'b1111001) && insn[23] &&
                  (insn[11:8] == 4'b0000) && insn[4];
  assign bad = !pat_ok || (!f_l && imm[5:3] == 3'b000) ||
               (f_q && (insn[12] || insn[0]));

  always_comb begin
    if (f_l) begin
      sz = 2'd3; cnt = 7'd64 - {1'b0, imm};
    end else if (imm[5]) begin
      sz = 2'd2; cnt = 7'd64 - {1'b0, imm};
    end else if (imm[4]) begin
      sz = 2'd1; cnt = 7'd32 - {1'b0, imm};
    end else begin
      sz = 2'd0; cnt = 7'd16 - {1'b0, imm};
    end
  end

  for (genvar s = 0; s < 4; s++) begin : g_size
    localparam int W = 8 << s;
    localparam logic [6:0] WL = 7'(W);
    localparam logic [6:0] WM = 7'(W - 1);
    for (genvar k = 0; k < VW / W; k++) begin : g_lane
      logic [W-1:0] ln, lg, ar;
      logic [6:0]   amt;
      assign ln  = src_vec[k*W +: W];
      assign amt = (cnt >= WL) ? WM : cnt;
      assign lg  = (cnt >= WL) ? '0 : (ln >> cnt);
      assign ar  = $signed(ln) >>> amt;
      assign lane_res[s][k*W +: W] = f_u ? lg : ar;
    end
  end

  assign picked = lane_res[sz];
  assign shaped = f_q ? picked : {64'b0, picked[63:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_undef <= 1'b0;
      res_vec   <= '0;
      res_dst   <= '0;
    end else begin
      res_valid <= in_valid && !bad;
      res_undef <= in_valid && bad;
      res_vec   <= (in_valid && !bad) ? shaped : '0;
      res_dst   <= (in_valid && !bad) ? (f_q ? {1'b0, dreg[4:1]} : dreg) : '0;
    end
  end

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bad) |-> (cnt >= 7'd1 && cnt <= (7'd8 << sz)));

  assert_strobe_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_valid ^ res_undef));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && !res_undef));

  assert_undef_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_undef |-> (res_vec == '0 && res_dst == '0));

  assert_half_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !insn[6]) |=> (res_vec[127:64] == 64'b0));

  assert_quad_odd_rejected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[6] && (insn[12] || insn[0])) |=> res_undef);
endmodule

// File: tb/vshr_imm_unit_tb.sv
module vshr_imm_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] src_vec = '0;
  logic         res_valid, res_undef;
  logic [127:0] res_vec;
  logic [4:0]   res_dst;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [127:0] PAT_A = 128'h8123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;
  localparam logic [127:0] PAT_B = 128'h7F80_00FF_1234_8001_C000_0003_FFFF_0000;

  always #10 clk = ~clk;

  vshr_imm_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .src_vec(src_vec),
    .res_valid(res_valid), .res_undef(res_undef), .res_vec(res_vec), .res_dst(res_dst)
  );

  function automatic logic [31:0] mk(bit u, bit d, logic [5:0] i6, logic [3:0] vd,
                                     bit l, bit q, bit m, logic [3:0] vm);
    return {7'b1111001, u, 1'b1, d, i6, vd, 4'b0000, l, q, m, 1'b1, vm};
  endfunction

  function automatic logic [127:0] model(logic [127:0] op, int esz, int c, bit u, bit q);
    logic [127:0] r = '0;
    int top = q ? 128 : 64;
    for (int b = 0; b < top; b++) begin
      int base = (b / esz) * esz;
      int src = (b % esz) + c;
      if (src < esz) r[b] = op[base + src];
      else           r[b] = u ? 1'b0 : op[base + esz - 1];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] w, logic [127:0] op);
    @(negedge clk);
    insn = w; src_vec = op; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; insn = '0; src_vec = '0;
  endtask

  task automatic expect_ok(string req, logic [31:0] w, logic [127:0] op,
                           int esz, int c, logic [4:0] dst);
    send(w, op);
    chk(req, {res_valid, res_undef}, 2'b10);
    chk(req, res_vec, model(op, esz, c, w[24], w[6]));
    chk(req, res_dst, dst);
  endtask

  task automatic expect_undef(string req, logic [31:0] w);
    send(w, PAT_A);
    chk(req, {res_valid, res_undef}, 2'b01);
    chk(req, res_vec, '0);
    chk(req, res_dst, '0);
  endtask

  task automatic t_reset;
    chk("R11", {res_valid, res_undef, res_dst}, '0);
    chk("R11", res_vec, '0);
  endtask

  task automatic t_wide_lanes;
    expect_ok("R2", mk(1, 0, 6'd60, 4'd2, 1, 1, 0, 4'd4), PAT_A, 64, 4, 5'd1);
    expect_ok("R2", mk(0, 0, 6'd1, 4'd3, 1, 0, 0, 4'd5), PAT_A, 64, 63, 5'd3);
  endtask

  task automatic t_narrow_lanes;
    expect_ok("R3", mk(0, 1, 6'd13, 4'd4, 0, 1, 0, 4'd6), PAT_A, 8, 3, 5'd10);
    expect_ok("R3", mk(1, 0, 6'd31, 4'd1, 0, 0, 1, 4'd7), PAT_B, 16, 1, 5'd1);
    expect_ok("R3", mk(0, 0, 6'd20, 4'd0, 0, 1, 0, 4'd8), PAT_B, 16, 12, 5'd0);
    expect_ok("R3", mk(0, 0, 6'd40, 4'd6, 0, 1, 0, 4'd2), PAT_A, 32, 24, 5'd3);
  endtask

  task automatic t_sign_select;
    expect_ok("R6", mk(1, 0, 6'd12, 4'd0, 0, 1, 0, 4'd0), PAT_A, 8, 4, 5'd0);
    expect_ok("R6", mk(0, 0, 6'd12, 4'd0, 0, 1, 0, 4'd0), PAT_A, 8, 4, 5'd0);
  endtask

  task automatic t_full_width;
    send(mk(1, 0, 6'd0, 4'd0, 1, 1, 0, 4'd0), PAT_A);
    chk("R7", res_vec, '0);
    send(mk(0, 0, 6'd0, 4'd0, 1, 1, 0, 4'd0), PAT_A);
    chk("R7", res_vec, {{64{1'b1}}, {64{1'b1}}});
    send(mk(0, 0, 6'd8, 4'd0, 0, 1, 0, 4'd0), PAT_B);
    chk("R7", res_vec, 128'h00FF_00FF_0000_FF00_FF00_0000_FFFF_0000);
  endtask

  task automatic t_half;
    send(mk(1, 0, 6'd56, 4'd0, 0, 0, 0, 4'd0), {64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0});
    chk("R8", res_vec, {64'b0, 64'h0012_3456_009A_BCDE});
  endtask

  task automatic t_dest;
    expect_ok("R9", mk(1, 1, 6'd63, 4'd15, 1, 0, 0, 4'd0), PAT_A, 64, 1, 5'd31);
    expect_ok("R9", mk(1, 1, 6'd63, 4'd14, 1, 1, 1, 4'd0), PAT_A, 64, 1, 5'd15);
  endtask

  task automatic t_illegal;
    expect_undef("R4", mk(1, 0, 6'd7, 4'd0, 0, 0, 0, 4'd0));
    expect_undef("R5", mk(1, 0, 6'd40, 4'd1, 0, 1, 0, 4'd0));
    expect_undef("R5", mk(1, 0, 6'd40, 4'd0, 0, 1, 0, 4'd3));
    expect_undef("R1", mk(1, 0, 6'd40, 4'd0, 0, 0, 0, 4'd0) ^ 32'h0000_0100);
    expect_undef("R1", mk(1, 0, 6'd40, 4'd0, 0, 0, 0, 4'd0) & ~32'h0000_0010);
    expect_undef("R1", mk(1, 0, 6'd40, 4'd0, 0, 0, 0, 4'd0) & ~32'h0080_0000);
  endtask

  task automatic t_idle;
    send(mk(1, 0, 6'd40, 4'd0, 0, 0, 0, 4'd0), PAT_A);
    @(negedge clk);
    chk("R10", {res_valid, res_undef}, 2'b00);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_wide_lanes();
    t_narrow_lanes();
    t_sign_select();
    t_full_width();
    t_half();
    t_dest();
    t_illegal();
    t_idle();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule